// File: doc/BRIEF.md
# Grouped Interrupt Aggregation Controller

This block gathers sixty-four interrupt lines, arranged as four groups of sixteen: local bus, LPC, PCI/device and non-maskable. Every line passes through its own polarity and trigger conditioning and is then held in its group's request register. Each group has its own mask. A summary word shows which groups hold at least one unmasked pending request. Two outputs are driven from it: one for the processor's ordinary interrupt input and one for the non-maskable input.

Software configures and services the block over a plain single-cycle register bus. Writes take effect at the next clock edge. Reads are combinational from the addressed register. For each group, an optional helper gives the lowest unmasked pending source number, so a dispatcher can find the source to service first without scanning.

Top module: `irq_group_aggr`

## Requirements
- R1: After reset every mask bit is 1, every trigger and polarity bit is 0, every request bit is 0, and both `irq_o` and `nmi_o` are low.
- R2: Register map on a 5-bit address. When address bit 4 is 0, bits 3:2 select the group (0 local bus, 1 LPC, 2 PCI/device, 3 non-maskable) and bits 1:0 select the register (0 mask, 1 trigger, 2 polarity, 3 request). Mask, trigger and polarity are read/write. Address 0x10 is the read-only summary. Every other address reads 0. A write to the summary or to an unused address changes nothing. Source n of group g is `src_in[16*g+n]` and maps to bit n of that group's registers.
- R3: A polarity bit of 1 makes its source active high. A polarity bit of 0 inverts the raw input before it is sampled or edge-detected.
- R4: A source in level mode (trigger bit 0) has its request bit equal to its conditioned input as sampled at the previous clock edge. Writes to the request register do not alter level-mode bits.
- R5: A source in edge mode (trigger bit 1) sets its request bit at the edge after the conditioned input is seen 1 having been 0 at the edge before. The bit stays set until software clears it.
- R6: A write to a group's request register clears every edge-mode bit whose write-data bit is 0 and leaves the bits written 1 unchanged. Writing zero therefore clears all edge requests of the group at once. A new edge arriving in the same cycle as a clear wins and sets the bit.
- R7: A mask bit of 1 blocks its source. Summary bit g (bit 0 local bus, 1 LPC, 2 PCI/device, 3 non-maskable) is the OR over the group of request AND NOT mask. Request reads return unmasked values.
- R8: `irq_o` is high exactly when summary bit 0, 1 or 2 is set. `nmi_o` equals summary bit 3.
- R9: `first_valid[g]` equals summary bit g. `first_idx[4*g+3:4*g]` holds the lowest source number whose request is set and unmasked, and holds 0 when there is none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register (combinational) |
| src_in | input | 64 | Raw interrupt lines, sixteen per group |
| irq_o | output | 1 | Combined ordinary interrupt |
| nmi_o | output | 1 | Non-maskable interrupt |
| first_valid | output | 4 | Per-group unmasked pending flag |
| first_idx | output | 16 | Per-group lowest unmasked pending source, 4 bits per group |

## Verification
The assertions assume that `src_in`, `bus_wr`, `bus_addr` and `bus_wdata` are synchronous to `clk` and steady around its rising edge. Edge detection compares samples taken on successive edges and has no synchronizer of its own. The stimulus satisfies this by changing every input only on the falling edge. Stickiness of edge-mode bits is checked only where no request write clears them, and the assertions do not depend on the order of writes to the trigger register. The stimulus therefore switches trigger modes and issues request clears freely, mixing random and all-zero write data.

// File: rtl/irqa_pkg.sv
package irqa_pkg;
  localparam int KIND_W = 2;

  typedef enum logic [KIND_W-1:0] {
    RK_MASK = 2'd0,
    RK_TRIG = 2'd1,
    RK_POL  = 2'd2,
    RK_REQ  = 2'd3
  } reg_kind_e;

  localparam int G_LBUS = 0;
  localparam int G_LPC  = 1;
  localparam int G_PCI  = 2;
  localparam int G_NMI  = 3;
endpackage

// File: rtl/irqa_cfg_reg.sv
module irqa_cfg_reg #(
  parameter int          W       = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (we) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/irqa_req_latch.sv
module irqa_req_latch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] trig,
  input  logic         clr_en,
  input  logic [W-1:0] clr_keep,
  output logic [W-1:0] req_q
);
  logic [W-1:0] cond;
  logic [W-1:0] cond_q;
  logic [W-1:0] rise;
  logic [W-1:0] keep;
  logic [W-1:0] req_nxt;

  always_comb begin
    // active-high when pol=1, inverted when pol=0
    cond    = ~(src ^ pol);
    rise    = cond & ~cond_q;
    keep    = clr_en ? clr_keep : '1;
    req_nxt = (trig & ((req_q & keep) | rise)) | (~trig & cond);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= '0;
      req_q  <= '0;
    end else begin
      cond_q <= cond;
      req_q  <= req_nxt;
    end
  end
endmodule

// File: rtl/irqa_lowest.sv
module irqa_lowest #(
  parameter int W     = 16,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic             valid,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
    valid = |vec;
  end
endmodule

// File: rtl/irqa_group.sv
module irqa_group #(
  parameter int W        = 16,
  parameter int IDX_W    = $clog2(W),
  parameter bit FIRST_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     src,
  input  logic [W-1:0]     wdata,
  input  logic             we_mask,
  input  logic             we_trig,
  input  logic             we_pol,
  input  logic             we_req,
  output logic [W-1:0]     mask_q,
  output logic [W-1:0]     trig_q,
  output logic [W-1:0]     pol_q,
  output logic [W-1:0]     req_q,
  output logic             pend,
  output logic             first_vld,
  output logic [IDX_W-1:0] first_idx
);
  logic [W-1:0] live;

  irqa_cfg_reg #(.W(W), .RST_VAL({W{1'b1}})) u_mask (
    .clk(clk), .rst_n(rst_n), .we(we_mask), .d(wdata), .q(mask_q)
  );
  irqa_cfg_reg #(.W(W), .RST_VAL({W{1'b0}})) u_trig (
    .clk(clk), .rst_n(rst_n), .we(we_trig), .d(wdata), .q(trig_q)
  );
  irqa_cfg_reg #(.W(W), .RST_VAL({W{1'b0}})) u_pol (
    .clk(clk), .rst_n(rst_n), .we(we_pol), .d(wdata), .q(pol_q)
  );

  irqa_req_latch #(.W(W)) u_req (
    .clk(clk), .rst_n(rst_n), .src(src), .pol(pol_q), .trig(trig_q),
    .clr_en(we_req), .clr_keep(wdata), .req_q(req_q)
  );

  assign live = req_q & ~mask_q;
  assign pend = |live;

  generate
    if (FIRST_EN) begin : g_first
      irqa_lowest #(.W(W), .IDX_W(IDX_W)) u_low (
        .vec(live), .valid(first_vld), .idx(first_idx)
      );
    end else begin : g_nofirst
      assign first_vld = 1'b0;
      assign first_idx = '0;
    end
  endgenerate
endmodule

// File: rtl/irq_group_aggr.sv
module irq_group_aggr
  import irqa_pkg::*;
#(
  parameter  int NUM_GRP     = 4,
  parameter  int SRC_PER_GRP = 16,
  parameter  bit FIRST_EN    = 1'b1,
  localparam int IDX_W       = $clog2(SRC_PER_GRP),
  localparam int GSEL_W      = $clog2(NUM_GRP),
  localparam int ADDR_W      = GSEL_W + KIND_W + 1,
  localparam int SRC_W       = NUM_GRP * SRC_PER_GRP
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [SRC_PER_GRP-1:0]   bus_wdata,
  output logic [SRC_PER_GRP-1:0]   bus_rdata,
  input  logic [SRC_W-1:0]         src_in,
  output logic                     irq_o,
  output logic                     nmi_o,
  output logic [NUM_GRP-1:0]       first_valid,
  output logic [NUM_GRP*IDX_W-1:0] first_idx
);
  logic                    addr_grp;
  logic                    addr_status;
  logic [GSEL_W-1:0]       gsel;
  reg_kind_e               kind;

  logic [SRC_PER_GRP-1:0]  mask_v [NUM_GRP];
  logic [SRC_PER_GRP-1:0]  trig_v [NUM_GRP];
  logic [SRC_PER_GRP-1:0]  pol_v  [NUM_GRP];
  logic [SRC_PER_GRP-1:0]  req_v  [NUM_GRP];
  logic [NUM_GRP-1:0]      grp_pend;

  logic [SRC_W-1:0]        req_all;
  logic [SRC_W-1:0]        mask_all;
  logic [SRC_W-1:0]        trig_all;
  logic [SRC_W-1:0]        pol_all;

  assign addr_grp    = ~bus_addr[ADDR_W-1];
  assign addr_status = bus_addr[ADDR_W-1] & (bus_addr[ADDR_W-2:0] == '0);
  assign gsel        = bus_addr[KIND_W +: GSEL_W];
  assign kind        = reg_kind_e'(bus_addr[KIND_W-1:0]);

  generate
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      logic sel;
      assign sel = bus_wr & addr_grp & (gsel == GSEL_W'(g));

      irqa_group #(.W(SRC_PER_GRP), .IDX_W(IDX_W), .FIRST_EN(FIRST_EN)) u_grp (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (src_in[g*SRC_PER_GRP +: SRC_PER_GRP]),
        .wdata     (bus_wdata),
        .we_mask   (sel & (kind == RK_MASK)),
        .we_trig   (sel & (kind == RK_TRIG)),
        .we_pol    (sel & (kind == RK_POL)),
        .we_req    (sel & (kind == RK_REQ)),
        .mask_q    (mask_v[g]),
        .trig_q    (trig_v[g]),
        .pol_q     (pol_v[g]),
        .req_q     (req_v[g]),
        .pend      (grp_pend[g]),
        .first_vld (first_valid[g]),
        .first_idx (first_idx[g*IDX_W +: IDX_W])
      );

      assign req_all [g*SRC_PER_GRP +: SRC_PER_GRP] = req_v[g];
      assign mask_all[g*SRC_PER_GRP +: SRC_PER_GRP] = mask_v[g];
      assign trig_all[g*SRC_PER_GRP +: SRC_PER_GRP] = trig_v[g];
      assign pol_all [g*SRC_PER_GRP +: SRC_PER_GRP] = pol_v[g];
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (addr_grp) begin
      unique case (kind)
        RK_MASK: bus_rdata = mask_v[gsel];
        RK_TRIG: bus_rdata = trig_v[gsel];
        RK_POL:  bus_rdata = pol_v[gsel];
        RK_REQ:  bus_rdata = req_v[gsel];
        default: bus_rdata = '0;
      endcase
    end else if (addr_status) begin
      bus_rdata[NUM_GRP-1:0] = grp_pend;
    end
  end

  // last group is the non-maskable one; all others feed the ordinary line
  assign irq_o = |grp_pend[NUM_GRP-2:0];
  assign nmi_o = grp_pend[NUM_GRP-1];
endmodule

// File: rtl/irqa_checker.sv
module irqa_checker
  import irqa_pkg::*;
#(
  parameter  int NUM_GRP     = 4,
  parameter  int SRC_PER_GRP = 16,
  parameter  bit FIRST_EN    = 1'b1,
  localparam int GSEL_W      = $clog2(NUM_GRP),
  localparam int ADDR_W      = GSEL_W + KIND_W + 1,
  localparam int SRC_W       = NUM_GRP * SRC_PER_GRP
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_wr,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [SRC_PER_GRP-1:0] bus_wdata,
  input logic [SRC_PER_GRP-1:0] bus_rdata,
  input logic [SRC_W-1:0]       src_in,
  input logic                   irq_o,
  input logic                   nmi_o,
  input logic [NUM_GRP-1:0]     first_valid,
  input logic [SRC_W-1:0]       req_all,
  input logic [SRC_W-1:0]       mask_all,
  input logic [SRC_W-1:0]       trig_all,
  input logic [SRC_W-1:0]       pol_all
);
  logic [SRC_W-1:0] keep_c;
  logic [SRC_W-1:0] held_c;
  logic [SRC_W-1:0] cond_c;
  logic             at_status;

  always_comb begin
    keep_c = '1;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (bus_wr && !bus_addr[ADDR_W-1] &&
          bus_addr[KIND_W +: GSEL_W] == GSEL_W'(g) &&
          bus_addr[KIND_W-1:0] == RK_REQ)
        keep_c[g*SRC_PER_GRP +: SRC_PER_GRP] = bus_wdata;
    end
    held_c    = req_all & trig_all & keep_c;
    cond_c    = pol_all ~^ src_in;
    at_status = bus_addr == {1'b1, {(ADDR_W-1){1'b0}}};
  end

  // R1
  a_r1_masks_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask_all == '1));

  // R4
  a_r4_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_all != '1) |=> ((req_all & ~$past(trig_all)) == ($past(cond_c) & ~$past(trig_all))));

  // R5
  a_r5_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (held_c != '0) |=> ((req_all & $past(held_c)) == $past(held_c)));

  // R7
  a_r7_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_all == '1) |-> (!irq_o && !nmi_o));

  // R8
  a_r8_outputs_match_summary: assert property (@(posedge clk) disable iff (!rst_n)
    at_status |-> ((irq_o == |bus_rdata[NUM_GRP-2:0]) && (nmi_o == bus_rdata[NUM_GRP-1])));

  // R9
  a_r9_first_valid_summary: assert property (@(posedge clk) disable iff (!rst_n)
    (at_status && FIRST_EN) |-> (first_valid == bus_rdata[NUM_GRP-1:0]));
endmodule

bind irq_group_aggr irqa_checker #(
  .NUM_GRP(NUM_GRP), .SRC_PER_GRP(SRC_PER_GRP), .FIRST_EN(FIRST_EN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
  .irq_o(irq_o), .nmi_o(nmi_o), .first_valid(first_valid),
  .req_all(req_all), .mask_all(mask_all), .trig_all(trig_all), .pol_all(pol_all)
);

// File: tb/tb_irq_group_aggr.sv
module tb_irq_group_aggr;
  localparam int NG = 4;
  localparam int SW = 16;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [63:0] src_in;
  logic        irq_o;
  logic        nmi_o;
  logic [3:0]  first_valid;
  logic [15:0] first_idx;

  int    n_cmp;
  int    n_bad;
  bit    done;
  string cur_tag;

  logic [15:0] m_mask [NG];
  logic [15:0] m_trig [NG];
  logic [15:0] m_pol  [NG];
  logic [15:0] m_req  [NG];
  logic [15:0] m_prev [NG];

  irq_group_aggr dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
    .irq_o(irq_o), .nmi_o(nmi_o), .first_valid(first_valid), .first_idx(first_idx)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // behavioural reference, one update per rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NG; g++) begin
        m_mask[g] = 16'hFFFF; m_trig[g] = 16'h0; m_pol[g] = 16'h0;
        m_req[g]  = 16'h0;    m_prev[g] = 16'h0;
      end
    end else begin
      for (int g = 0; g < NG; g++) begin
        for (int n = 0; n < SW; n++) begin
          bit raw, c, was, clr;
          raw = src_in[g*SW+n];
          c   = m_pol[g][n] ? raw : !raw;
          was = m_prev[g][n];
          clr = bus_wr && bus_addr == 5'(g*4+3) && !bus_wdata[n];
          if (!m_trig[g][n]) m_req[g][n] = c;
          else begin
            if (clr) m_req[g][n] = 1'b0;
            if (c && !was) m_req[g][n] = 1'b1;
          end
          m_prev[g][n] = c;
        end
        if (bus_wr && bus_addr == 5'(g*4+0)) m_mask[g] = bus_wdata;
        if (bus_wr && bus_addr == 5'(g*4+1)) m_trig[g] = bus_wdata;
        if (bus_wr && bus_addr == 5'(g*4+2)) m_pol[g]  = bus_wdata;
      end
    end
  end

  function automatic logic [15:0] exp_status();
    logic [15:0] s = '0;
    for (int g = 0; g < NG; g++) s[g] = |(m_req[g] & ~m_mask[g]);
    return s;
  endfunction

  function automatic logic [15:0] exp_rdata(logic [4:0] a);
    if (!a[4]) begin
      case (a[1:0])
        2'd0:    return m_mask[a[3:2]];
        2'd1:    return m_trig[a[3:2]];
        2'd2:    return m_pol[a[3:2]];
        default: return m_req[a[3:2]];
      endcase
    end
    if (a == 5'h10) return exp_status();
    return 16'h0;
  endfunction

  function automatic logic [15:0] exp_first();
    logic [15:0] r = '0;
    for (int g = 0; g < NG; g++) begin
      logic [15:0] live = m_req[g] & ~m_mask[g];
      for (int n = SW - 1; n >= 0; n--) if (live[n]) r[g*4 +: 4] = 4'(n);
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [15:0] st = exp_status();
    chk((bus_addr == 5'h10) ? "R7 summary" : cur_tag, 32'(bus_rdata), 32'(exp_rdata(bus_addr)));
    chk("R8 irq_o", 32'(irq_o), 32'(|st[2:0]));
    chk("R8 nmi_o", 32'(nmi_o), 32'(st[3]));
    chk("R9 first_valid", 32'(first_valid), 32'(st[3:0]));
    chk("R9 first_idx", 32'(first_idx), 32'(exp_first()));
  endtask

  task automatic step(bit wr, logic [4:0] a, logic [15:0] d, logic [63:0] s);
    @(negedge clk);
    check_all();
    bus_wr = wr; bus_addr = a; bus_wdata = d; src_in = s;
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] s;
    n_cmp = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; src_in = '0;
    void'($urandom(7));
    cur_tag = "R1 reset";
    repeat (3) @(negedge clk);
    // R1: reset state of every register and output
    for (int a = 0; a < 17; a++) step(1'b0, 5'(a), 16'h0, 64'h0);
    rst_n = 1'b1;
    for (int a = 0; a < 17; a++) step(1'b0, 5'(a), 16'h0, 64'h0);

    // R2: write/readback, read-only summary, unused addresses
    cur_tag = "R2 regmap";
    for (int a = 0; a < 16; a++) begin
      if (a % 4 != 3) begin
        step(1'b1, 5'(a), 16'($urandom()), 64'h0);
        step(1'b0, 5'(a), 16'h0, 64'h0);
      end
    end
    step(1'b1, 5'h10, 16'hFFFF, 64'h0);
    step(1'b1, 5'h15, 16'hFFFF, 64'h0);
    step(1'b1, 5'h1F, 16'hA5A5, 64'h0);
    for (int a = 16; a < 32; a++) step(1'b0, 5'(a), 16'h0, 64'h0);
    for (int a = 0; a < 16; a++) step(1'b0, 5'(a), 16'h0, 64'h0);

    // R3 R4: level mode, unmasked, mixed polarity
    cur_tag = "R3 R4 level/polarity";
    for (int g = 0; g < NG; g++) begin
      step(1'b1, 5'(g*4+0), 16'h0, 64'h0);
      step(1'b1, 5'(g*4+1), 16'h0, 64'h0);
      step(1'b1, 5'(g*4+2), 16'($urandom()), 64'h0);
    end
    for (int i = 0; i < 60; i++) begin
      s = rnd64();
      step((i % 5) == 0, 5'((i % 4) * 4 + 3), 16'h0, s);
    end
    for (int i = 0; i < 40; i++) step(1'b0, 5'((i % 4) * 4 + 3), 16'h0, rnd64());

    // R5 R6: edge mode latching and clearing
    cur_tag = "R5 R6 edge/clear";
    for (int g = 0; g < NG; g++) step(1'b1, 5'(g*4+1), 16'hFFFF, 64'h0);
    for (int i = 0; i < 300; i++) begin
      bit w = ($urandom() % 4) == 0;
      logic [15:0] d = (($urandom() % 2) == 0) ? 16'h0 : 16'($urandom());
      s = (($urandom() % 3) == 0) ? rnd64() : src_in;
      step(w, 5'(($urandom() % 4) * 4 + 3), d, s);
    end
    for (int g = 0; g < NG; g++) step(1'b1, 5'(g*4+3), 16'h0, src_in);

    // R7 R8 R9: masks, trigger mix, full random traffic
    cur_tag = "R7 R8 R9 mixed";
    for (int i = 0; i < 1500; i++) begin
      bit w = ($urandom() % 3) == 0;
      logic [4:0] a = 5'($urandom() % 18);
      logic [15:0] d = 16'($urandom());
      if (($urandom() % 4) == 0) d = 16'h0;
      if (($urandom() % 2) == 0) s = rnd64();
      step(w, a, d, s);
    end
    // single-source priority sweep for R9
    for (int g = 0; g < NG; g++) begin
      step(1'b1, 5'(g*4+0), 16'h0, 64'h0);
      step(1'b1, 5'(g*4+1), 16'h0, 64'h0);
      step(1'b1, 5'(g*4+2), 16'hFFFF, 64'h0);
    end
    for (int n = 0; n < 64; n++) step(1'b0, 5'h10, 16'h0, (64'h1 << n) | (64'h1 << 63));
    step(1'b0, 5'h10, 16'h0, 64'h0);
    step(1'b0, 5'h10, 16'h0, 64'h0);
    finish_run();
  end
endmodule